// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the receiver should keep it. It looks only at the six destination-address bytes at the head of the frame and at a two-bit match mode chosen by the host. The destination bytes arrive one per `byte_valid` cycle, and the first byte carries a start-of-frame flag. Gaps between bytes are allowed. One clock after the sixth byte is taken, the block pulses `dec_valid` for a single cycle, with `dec_accept` giving the verdict.

The host programs the filter through a small byte-wide register port. Offsets 0 to 5 hold the station address, and offset 0 is the byte seen first on the wire. Offset 6 holds the receive command, whose bits 7:6 select the match mode. The comparison runs as the bytes arrive and keeps running match flags, so the destination is never buffered. The station address and the mode are captured when a frame starts. Host writes made while a frame is being compared therefore apply from the next frame.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0, all six station bytes are 0x00, and the match mode is 00.
- R2: Mode 00 (receive command bits 7:6 = 00) rejects every frame: `dec_accept` is 0 whenever `dec_valid` is 1.
- R3: Mode 01 accepts every frame whatever its destination.
- R4: In modes 10 and 11 a frame whose six destination bytes equal station bytes 0..5, in that order, is accepted.
- R5: In modes 10 and 11 the broadcast destination FF:FF:FF:FF:FF:FF is accepted. In mode 10 every other destination, multicast included, is rejected.
- R6: In mode 11 a frame whose first destination byte has bit 0 set is accepted. A frame with that bit clear that is neither the station address nor broadcast is rejected.
- R7: `dec_valid` is high for exactly one cycle, the cycle that follows the clock edge at which the sixth destination byte is taken.
- R8: A byte with `byte_sof` set always starts a new comparison and discards any partly compared frame. Only the restarted frame produces a decision.
- R9: A write to a station byte or to the mode while a frame is being compared has no effect on that frame's decision. It applies from the next frame.
- R10: Bytes taken without a preceding start of frame, and bytes that follow the sixth byte, produce no decision.
- R11: Register offsets: 0..5 are station bytes, and offset 0 is the first byte on the wire. Offset 6 is the receive command, with the mode in bits 7:6. A write to offset 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| byte_valid | input | 1 | A destination byte is present this cycle |
| byte_sof | input | 1 | Present byte is the first of a frame |
| byte_data | input | 8 | Destination byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Verdict, meaningful while `dec_valid` is 1 |

## Verification
A corrupted running match flag or a misaligned byte index shows up at the ports as a wrong `dec_accept` on the very next decision, one cycle after the sixth byte. A stuck or skipped byte counter shows up as a missing, early or repeated `dec_valid` within the same frame. A station or mode snapshot that is taken at the wrong moment only shows when host writes land mid-frame, so those writes are driven on purpose. Random frames that mix station, broadcast, multicast and unicast destinations across all four modes test every verdict path against a model kept in the bench.

// File: rtl/daf_pkg.sv
package daf_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_ALL     = 2'b01,
        MODE_UC_BC   = 2'b10,
        MODE_UC_BC_MC = 2'b11
    } match_mode_e;
endpackage

// File: rtl/daf_addr_regs.sv
module daf_addr_regs
    import daf_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 6,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NUM_BYTES*BYTE_W-1:0] station,
    output match_mode_e                 mode
);
    localparam int CMD_OFF = NUM_BYTES;

    typedef struct packed {
        logic [NUM_BYTES*BYTE_W-1:0] sta;
        match_mode_e                 mode;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_BYTES-1:0] byte_hit;
    logic                 cmd_hit;

    // one decoded write strobe per station byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_dec
        assign byte_hit[g] = we && (addr == ADDR_W'(g));
    end
    assign cmd_hit = we && (addr == ADDR_W'(CMD_OFF));

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_hit[i]) regs_d.sta[i*BYTE_W +: BYTE_W] = wdata;
        end
        if (cmd_hit) regs_d.mode = match_mode_e'(wdata[BYTE_W-1 -: 2]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.sta  <= '0;
            regs_q.mode <= MODE_OFF;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign station = regs_q.sta;
    assign mode    = regs_q.mode;
endmodule

// File: rtl/daf_byte_matcher.sv
module daf_byte_matcher
    import daf_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 6,
    parameter int CNT_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_valid,
    input  logic                        byte_sof,
    input  logic [BYTE_W-1:0]           byte_data,
    input  logic [NUM_BYTES*BYTE_W-1:0] live_sta,
    input  match_mode_e                 live_mode,
    output logic                        last_byte,
    output logic                        st_hit,
    output logic                        bc_hit,
    output logic                        mc_hit,
    output match_mode_e                 frame_mode,
    output logic                        active_q,
    output logic [CNT_W-1:0]            cnt_q
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BYTES - 1);

    typedef struct packed {
        logic                        active;
        logic [CNT_W-1:0]            cnt;
        logic                        st_ok;
        logic                        bc_ok;
        logic                        mc;
        logic [NUM_BYTES*BYTE_W-1:0] snap_sta;
        match_mode_e                 snap_mode;
    } mst_t;

    mst_t m_d, m_q;
    logic                        take;
    logic [CNT_W-1:0]            idx;
    logic [NUM_BYTES*BYTE_W-1:0] ref_sta;
    logic [BYTE_W-1:0]           ref_byte;
    logic                        prev_st, prev_bc;
    logic                        st_now, bc_now, mc_now;

    always_comb begin
        take     = byte_valid && (byte_sof || m_q.active);
        idx      = byte_sof ? '0 : m_q.cnt;
        ref_sta  = byte_sof ? live_sta : m_q.snap_sta;
        ref_byte = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (idx == CNT_W'(i)) ref_byte = ref_sta[i*BYTE_W +: BYTE_W];
        end
        prev_st  = byte_sof ? 1'b1 : m_q.st_ok;
        prev_bc  = byte_sof ? 1'b1 : m_q.bc_ok;
        st_now   = prev_st && (byte_data == ref_byte);
        bc_now   = prev_bc && (&byte_data);
        mc_now   = byte_sof ? byte_data[0] : m_q.mc;

        m_d = m_q;
        if (take) begin
            m_d.st_ok = st_now;
            m_d.bc_ok = bc_now;
            m_d.mc    = mc_now;
            if (idx == LAST_IDX) begin
                m_d.active = 1'b0;
                m_d.cnt    = '0;
            end else begin
                m_d.active = 1'b1;
                m_d.cnt    = idx + 1'b1;
            end
            if (byte_sof) begin
                m_d.snap_sta  = live_sta;
                m_d.snap_mode = live_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign last_byte  = take && (idx == LAST_IDX);
    assign st_hit     = st_now;
    assign bc_hit     = bc_now;
    assign mc_hit     = mc_now;
    assign frame_mode = byte_sof ? live_mode : m_q.snap_mode;
    assign active_q   = m_q.active;
    assign cnt_q      = m_q.cnt;
endmodule

// File: rtl/daf_mode_decide.sv
module daf_mode_decide
    import daf_pkg::*;
(
    input  match_mode_e mode,
    input  logic        st_hit,
    input  logic        bc_hit,
    input  logic        mc_hit,
    output logic        accept
);
    always_comb begin
        unique case (mode)
            MODE_OFF:      accept = 1'b0;
            MODE_ALL:      accept = 1'b1;
            MODE_UC_BC:    accept = st_hit || bc_hit;
            MODE_UC_BC_MC: accept = st_hit || bc_hit || mc_hit;
            default:       accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 6,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              byte_valid,
    input  logic              byte_sof,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    typedef struct packed {
        logic valid;
        logic accept;
    } dec_t;

    logic [NUM_BYTES*BYTE_W-1:0] station;
    match_mode_e                 mode;
    logic                        last_byte, st_hit, bc_hit, mc_hit, accept_raw;
    match_mode_e                 frame_mode;
    logic                        active_q;
    logic [CNT_W-1:0]            cnt_q;
    dec_t                        dec_d, dec_q;

    daf_addr_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .station(station), .mode(mode)
    );

    daf_byte_matcher #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_data(byte_data), .live_sta(station), .live_mode(mode),
        .last_byte(last_byte), .st_hit(st_hit), .bc_hit(bc_hit), .mc_hit(mc_hit),
        .frame_mode(frame_mode), .active_q(active_q), .cnt_q(cnt_q)
    );

    daf_mode_decide u_decide (
        .mode(frame_mode), .st_hit(st_hit), .bc_hit(bc_hit), .mc_hit(mc_hit),
        .accept(accept_raw)
    );

    always_comb begin
        dec_d.valid  = last_byte;
        dec_d.accept = last_byte && accept_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int NUM_BYTES = 6,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [1:0]       frame_mode,
    input logic             active_q,
    input logic [CNT_W-1:0] cnt_q
);
    p_off_rejects_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(frame_mode) == 2'b00) |-> !dec_accept);

    p_all_accepts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(frame_mode) == 2'b01) |-> dec_accept);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(byte_valid));

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= CNT_W'(NUM_BYTES - 1)));

    p_idle_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (cnt_q == '0));

    p_accept_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);
endmodule

bind dst_addr_filter daf_checker #(.NUM_BYTES(NUM_BYTES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .frame_mode(frame_mode), .active_q(active_q), .cnt_q(cnt_q)
);

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       reg_we = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic       byte_valid = 0;
    logic       byte_sof = 0;
    logic [7:0] byte_data = 0;
    logic       dec_valid, dec_accept;

    int n_cmp = 0;
    int n_bad = 0;
    logic [47:0] sta_m = '0;
    logic [1:0]  mode_m = 2'b00;

    always #4 clk = ~clk;

    dst_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .byte_valid(byte_valid), .byte_sof(byte_sof),
        .byte_data(byte_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic exp_acc(input logic [1:0] m, input logic [47:0] sta,
                                     input logic [47:0] dst);
        logic st, bc, mc;
        st = (dst == sta);
        bc = (dst == 48'hFFFF_FFFF_FFFF);
        mc = dst[0];
        case (m)
            2'b00: return 1'b0;
            2'b01: return 1'b1;
            2'b10: return st || bc;
            default: return st || bc || mc;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a[2:0]; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a < 6) sta_m[a*8 +: 8] = d;
        else if (a == 6) mode_m = d[7:6];
    endtask

    task automatic put(input logic [7:0] b, input logic s);
        @(negedge clk);
        byte_valid = 1; byte_sof = s; byte_data = b;
        @(negedge clk);
        byte_valid = 0; byte_sof = 0;
    endtask

    task automatic set_sta(input logic [47:0] a);
        for (int i = 0; i < 6; i++) wr(i, a[i*8 +: 8]);
    endtask

    // sends six bytes, checks the decision cycle and the cycle after it
    task automatic frame(input logic [47:0] dst, input string req);
        logic e;
        e = exp_acc(mode_m, sta_m, dst);
        for (int i = 0; i < 6; i++) put(dst[i*8 +: 8], i == 0);
        chk({req, " valid"}, dec_valid, 1'b1);
        chk({req, " accept"}, dec_accept, e);
        @(negedge clk);
        chk({req, " R7 pulse end"}, dec_valid, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] a, old;
        int r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid", dec_valid, 1'b0);
        chk("R1 accept", dec_accept, 1'b0);
        // R1 + R2: reset mode 00 rejects even a matching zero address
        frame(48'h0, "R1 R2 reset mode off");
        frame(48'hFFFF_FFFF_FFFF, "R2 broadcast in off");
        // R1: reset station is zero, visible in mode 10
        wr(6, 8'h80);
        frame(48'h0, "R1 station zero");
        // R11 byte order: offset 0 is first on the wire
        set_sta(48'h665544332210);
        frame(48'h665544332210, "R4 R11 station");
        frame(48'h102233445566, "R11 reversed");
        frame(48'hFFFF_FFFF_FFFF, "R5 broadcast");
        frame(48'h665544332211, "R5 multicast in mode 10");
        frame(48'hFFFF_FFFF_FF7F, "R5 near broadcast");
        // R6
        wr(6, 8'hC0);
        frame(48'h000000000001, "R6 multicast");
        frame(48'h000000000100, "R6 unicast other");
        frame(48'h665544332210, "R4 station mode 11");
        // R11: offset 7 changes nothing
        wr(7, 8'h00);
        frame(48'h0000000000A3, "R11 offset 7 ignored");
        // R3
        wr(6, 8'h40);
        frame(48'h123456789ABC, "R3 promiscuous");
        // R8: partial frame then restart
        wr(6, 8'h80);
        put(8'hFF, 1); put(8'hFF, 0); put(8'hFF, 0);
        chk("R8 no decision on partial", dec_valid, 1'b0);
        frame(48'h0A0B0C0D0E10, "R8 restart reject");
        put(8'h10, 1); put(8'h22, 0);
        frame(48'h665544332210, "R8 restart accept");
        // R10: bytes after sixth and bytes without sof
        for (int i = 0; i < 6; i++) begin
            put(8'hFF, 0);
            chk("R10 stray byte", dec_valid, 1'b0);
        end
        // R9: station write mid-frame
        old = sta_m;
        put(old[7:0], 1); put(old[15:8], 0);
        wr(4, 8'h99);
        for (int i = 2; i < 6; i++) put(old[i*8 +: 8], 0);
        chk("R9 sta write valid", dec_valid, 1'b1);
        chk("R9 sta write old address", dec_accept, 1'b1);
        frame(old, "R9 old address next frame");
        frame(sta_m, "R9 new address next frame");
        // R9: mode write mid-frame
        put(8'h01, 1); put(8'h00, 0);
        wr(6, 8'h00);
        for (int i = 2; i < 6; i++) put(8'h00, 0);
        chk("R9 mode write valid", dec_valid, 1'b1);
        chk("R9 mode write keeps 10", dec_accept, 1'b0);
        wr(6, 8'h40);
        put(8'h00, 1);
        wr(6, 8'h00);
        for (int i = 1; i < 6; i++) put(8'h00, 0);
        chk("R9 mode 01 kept", dec_accept, 1'b1);
        // random frames across modes
        for (int k = 0; k < 300; k++) begin
            if (k % 25 == 0) begin
                wr(6, {2'($urandom_range(0, 3)), 6'($urandom)});
                a = {$urandom, $urandom};
                a[0] = 1'b0;
                set_sta(a);
            end
            r = $urandom_range(0, 99);
            a = {$urandom, $urandom};
            if (r < 25) a = sta_m;
            else if (r < 40) a = 48'hFFFF_FFFF_FFFF;
            else if (r < 65) a[0] = 1'b1;
            else a[0] = 1'b0;
            frame(a, "R2 R3 R4 R5 R6 random");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule